// File: doc/BRIEF.md
# Cascaded Event Interrupt Multiplexer

This block gathers single-cycle event strobes from up to 96 sources into three pending words and drives three level interrupt lines from them. Each event carries a 7-bit number. Bits [6:5] of the number pick a pending word and bits [4:0] pick a bit within that word. Each interrupt line has three enable words of its own. A line is high while any pending bit is also enabled for that line. The two top bits of word 0 are cascade summaries. Bit 30 reports activity in word 1 and bit 31 reports activity in word 2. Software that only reads word 0 therefore still sees that the other words need attention.

Software reaches the pending and enable words through a simple register port. It has one write select and one independent read select, and read data comes out registered. Each pending word has its own write rule. Word 0 is write-one-to-clear, except that its cascade bits cannot be cleared this way. Word 1 cannot be written at all. Word 2 is write-one-to-clear, and when that clear empties word 2 the word-2 cascade bit is dropped with it. Event sources that withdraw a request use a separate single-event clear strobe, which maintains both cascade bits.

Top module: `evt_irq_mux`

## Requirements
- R1: On an event strobe, event-number bits [6:5] select pending word 0, 1 or 2 and bits [4:0] select the bit set in it. An event whose bits [6:5] equal 3 changes nothing.
- R2: An event in word 1 also sets bit 30 of word 0. An event in word 2 also sets bit 31 of word 0.
- R3: Output line A, B or C is high one clock after the state in which the OR over all three words of (pending AND that line's enable word) is nonzero. It is low one clock after that OR is zero.
- R4: A register write to pending word 0 clears each bit written as 1, except bits 31 and 30, which keep their value.
- R5: A register write to pending word 1 leaves all pending words unchanged.
- R6: A register write to pending word 2 clears each bit written as 1. If word 2 is then zero, bit 31 of word 0 is cleared as well.
- R7: A write to an enable word replaces it at once. The affected line rises or falls on the next clock with no new event.
- R8: The single-event clear strobe clears the numbered bit. If the clear leaves word 1 zero, bit 30 of word 0 is cleared. If it leaves word 2 zero, bit 31 of word 0 is cleared.
- R9: When an event sets a bit in the same cycle that a register write or a single-event clear would clear it, the bit ends up set. The cascade bit implied by the event also ends up set.
- R10: Synchronous reset clears every pending and enable word, the read data and all three output lines.
- R11: Select bits [3:2] choose the group (0 pending, 1 line-A enables, 2 line-B enables, 3 line-C enables) and bits [1:0] choose the word. Read data shows the selected word one clock after the select. Word index 3 reads zero, and writes to word index 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_vld | input | 1 | Event strobe |
| ev_num | input | 7 | Event number: word in [6:5], bit in [4:0] |
| clr_vld | input | 1 | Single-event clear strobe |
| clr_num | input | 7 | Number of the event to clear |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 4 | Write select: group [3:2], word [1:0] |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 4 | Read select: group [3:2], word [1:0] |
| reg_rdata | output | 32 | Registered read data |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |
| irq_c | output | 1 | Interrupt line C |

## Verification
The sharpest case is an event that sets a bit in the same cycle that a register write or a single-event clear removes it. A second case is a clear that empties word 1 or word 2 in the same cycle that an event lands in that word again. Both are driven in directed form: an event together with a write-one-to-clear of the same bit, and an event together with a strobe clear of the same number. The bench judges the result by reading back the pending word and word 0's cascade bits. Random cycles also mix events, strobe clears and writes freely. A bench model evaluates every cycle under the set-wins rule and compares the lines and the read data against it.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int N_WORDS = 3;
  localparam int N_LINES = 3;

  typedef enum logic [1:0] {
    GRP_PEND = 2'd0,
    GRP_EN_A = 2'd1,
    GRP_EN_B = 2'd2,
    GRP_EN_C = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/evt_pending_bank.sv
module evt_pending_bank
  import evt_irq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BIT_W  = $clog2(WORD_W)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             set_vld,
  input  logic [1:0]                       set_word,
  input  logic [BIT_W-1:0]                 set_bit,
  input  logic                             clr_vld,
  input  logic [1:0]                       clr_word,
  input  logic [BIT_W-1:0]                 clr_bit,
  input  logic                             wr_vld,
  input  logic [1:0]                       wr_word,
  input  logic [WORD_W-1:0]                wr_data,
  output logic [N_WORDS-1:0][WORD_W-1:0]   pend_q
);
  localparam int CAS1 = WORD_W - 2;
  localparam int CAS2 = WORD_W - 1;
  localparam logic [WORD_W-1:0] W0_WR_MASK = {2'b00, {(WORD_W-2){1'b1}}};

  logic [N_WORDS-1:0][WORD_W-1:0] set_m;
  logic [N_WORDS-1:0][WORD_W-1:0] clr_m;
  logic [N_WORDS-1:0][WORD_W-1:0] nxt;

  always_comb begin
    for (int w = 0; w < N_WORDS; w++) begin
      set_m[w] = '0;
      clr_m[w] = '0;
      if (set_vld && (set_word == 2'(w))) set_m[w][set_bit] = 1'b1;
      if (clr_vld && (clr_word == 2'(w))) clr_m[w][clr_bit] = 1'b1;
    end
    if (wr_vld) begin
      case (wr_word)
        2'd0:    clr_m[0] = clr_m[0] | (wr_data & W0_WR_MASK);
        2'd2:    clr_m[2] = clr_m[2] | wr_data;
        default: ;
      endcase
    end
    for (int w = 0; w < N_WORDS; w++) begin
      nxt[w] = (pend_q[w] & ~clr_m[w]) | set_m[w];
    end
    if ((|clr_m[1]) && (nxt[1] == '0)) nxt[0][CAS1] = 1'b0;
    if ((|clr_m[2]) && (nxt[2] == '0)) nxt[0][CAS2] = 1'b0;
    nxt[0] = nxt[0] | set_m[0];
    if (|set_m[1]) nxt[0][CAS1] = 1'b1;
    if (|set_m[2]) nxt[0][CAS2] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= nxt;
  end
endmodule

// File: rtl/evt_enable_bank.sv
module evt_enable_bank
  import evt_irq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         wr_vld,
  input  logic [1:0]                                   wr_grp,
  input  logic [1:0]                                   wr_word,
  input  logic [WORD_W-1:0]                            wr_data,
  output logic [N_LINES-1:0][N_WORDS-1:0][WORD_W-1:0]  en_q
);
  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      logic hit;
      assign hit = wr_vld && (wr_grp == 2'(l + 1)) && (wr_word == 2'(w));
      always_ff @(posedge clk) begin
        if (rst)      en_q[l][w] <= '0;
        else if (hit) en_q[l][w] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/evt_irq_reduce.sv
module evt_irq_reduce
  import evt_irq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_WORDS-1:0][WORD_W-1:0] pend,
  input  logic [N_WORDS-1:0][WORD_W-1:0] en,
  output logic                           irq_q
);
  logic [WORD_W-1:0] hits;

  always_comb begin
    hits = '0;
    for (int w = 0; w < N_WORDS; w++) hits = hits | (pend[w] & en[w]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |hits;
  end
endmodule

// File: rtl/evt_irq_mux.sv
module evt_irq_mux
  import evt_irq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BIT_W  = $clog2(WORD_W),
  parameter int EV_W   = BIT_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_vld,
  input  logic [EV_W-1:0]   ev_num,
  input  logic              clr_vld,
  input  logic [EV_W-1:0]   clr_num,
  input  logic              reg_wr,
  input  logic [3:0]        reg_wsel,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [3:0]        reg_rsel,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq_a,
  output logic              irq_b,
  output logic              irq_c
);
  logic [N_WORDS-1:0][WORD_W-1:0]              pend_w;
  logic [N_LINES-1:0][N_WORDS-1:0][WORD_W-1:0] en_w;
  logic [N_LINES-1:0]                          irq_w;
  logic                                        pend_wr;

  assign pend_wr = reg_wr && (reg_grp_e'(reg_wsel[3:2]) == GRP_PEND);

  evt_pending_bank #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .set_vld  (ev_vld),
    .set_word (ev_num[EV_W-1 -: 2]),
    .set_bit  (ev_num[BIT_W-1:0]),
    .clr_vld  (clr_vld),
    .clr_word (clr_num[EV_W-1 -: 2]),
    .clr_bit  (clr_num[BIT_W-1:0]),
    .wr_vld   (pend_wr),
    .wr_word  (reg_wsel[1:0]),
    .wr_data  (reg_wdata),
    .pend_q   (pend_w)
  );

  evt_enable_bank #(.WORD_W(WORD_W)) u_en (
    .clk     (clk),
    .rst     (rst),
    .wr_vld  (reg_wr),
    .wr_grp  (reg_wsel[3:2]),
    .wr_word (reg_wsel[1:0]),
    .wr_data (reg_wdata),
    .en_q    (en_w)
  );

  for (genvar l = 0; l < N_LINES; l++) begin : g_red
    evt_irq_reduce #(.WORD_W(WORD_W)) u_red (
      .clk   (clk),
      .rst   (rst),
      .pend  (pend_w),
      .en    (en_w[l]),
      .irq_q (irq_w[l])
    );
  end

  assign irq_a = irq_w[0];
  assign irq_b = irq_w[1];
  assign irq_c = irq_w[2];

  logic [WORD_W-1:0] rd_nxt;
  always_comb begin
    rd_nxt = '0;
    if (reg_rsel[1:0] != 2'd3) begin
      case (reg_grp_e'(reg_rsel[3:2]))
        GRP_PEND: rd_nxt = pend_w[reg_rsel[1:0]];
        GRP_EN_A: rd_nxt = en_w[0][reg_rsel[1:0]];
        GRP_EN_B: rd_nxt = en_w[1][reg_rsel[1:0]];
        default:  rd_nxt = en_w[2][reg_rsel[1:0]];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nxt;
  end
endmodule

// File: rtl/evt_irq_mux_chk.sv
module evt_irq_mux_chk
  import evt_irq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BIT_W  = $clog2(WORD_W),
  parameter int EV_W   = BIT_W + 2
) (
  input logic                                         clk,
  input logic                                         rst,
  input logic                                         ev_vld,
  input logic [EV_W-1:0]                              ev_num,
  input logic                                         clr_vld,
  input logic                                         reg_wr,
  input logic [3:0]                                   reg_wsel,
  input logic [N_WORDS-1:0][WORD_W-1:0]               pend_w,
  input logic [N_LINES-1:0][N_WORDS-1:0][WORD_W-1:0]  en_w,
  input logic                                         irq_a
);
  logic             ev0_q;
  logic [BIT_W-1:0] ev0_bit_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ev0_q     <= 1'b0;
      ev0_bit_q <= '0;
    end else begin
      ev0_q     <= ev_vld && (ev_num[EV_W-1 -: 2] == 2'd0);
      ev0_bit_q <= ev_num[BIT_W-1:0];
    end
  end

  AST_EVENT_SETS_BIT: assert property (@(posedge clk) disable iff (rst)
    ev0_q |-> pend_w[0][ev0_bit_q]); // R1

  AST_CASCADE_WORD1: assert property (@(posedge clk) disable iff (rst)
    (ev_vld && ev_num[EV_W-1 -: 2] == 2'd1) |=> pend_w[0][WORD_W-2]); // R2

  AST_CASCADE_WORD2: assert property (@(posedge clk) disable iff (rst)
    (ev_vld && ev_num[EV_W-1 -: 2] == 2'd2) |=> pend_w[0][WORD_W-1]); // R2

  AST_LINE_A_LEVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_a == $past(|((pend_w[0] & en_w[0][0]) | (pend_w[1] & en_w[0][1]) |
                               (pend_w[2] & en_w[0][2]))))); // R3

  AST_W0_CASCADE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wsel == 4'b0000 && !clr_vld && pend_w[0][WORD_W-1]) |=> pend_w[0][WORD_W-1]); // R4

  AST_W1_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wsel == 4'b0001 && !ev_vld && !clr_vld) |=> $stable(pend_w)); // R5
endmodule

bind evt_irq_mux evt_irq_mux_chk #(.WORD_W(WORD_W), .BIT_W(BIT_W), .EV_W(EV_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ev_vld   (ev_vld),
  .ev_num   (ev_num),
  .clr_vld  (clr_vld),
  .reg_wr   (reg_wr),
  .reg_wsel (reg_wsel),
  .pend_w   (pend_w),
  .en_w     (en_w),
  .irq_a    (irq_a)
);

// File: tb/evt_irq_mux_test.sv
module evt_irq_mux_test;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYC   = 3000;

  logic        clk = 1'b0;
  logic        rst;
  logic        ev_vld, clr_vld, reg_wr;
  logic [6:0]  ev_num, clr_num;
  logic [3:0]  reg_wsel, reg_rsel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq_a, irq_b, irq_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_mux uut (
    .clk(clk), .rst(rst), .ev_vld(ev_vld), .ev_num(ev_num),
    .clr_vld(clr_vld), .clr_num(clr_num), .reg_wr(reg_wr),
    .reg_wsel(reg_wsel), .reg_wdata(reg_wdata), .reg_rsel(reg_rsel),
    .reg_rdata(reg_rdata), .irq_a(irq_a), .irq_b(irq_b), .irq_c(irq_c)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [2:0][31:0]       mp;
  logic [2:0][2:0][31:0]  me;
  logic [2:0]             mirq;
  logic [31:0]            mrd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sel_val(input logic [3:0] s);
    if (s[1:0] == 2'd3) return 32'h0;
    if (s[3:2] == 2'd0) return mp[s[1:0]];
    return me[s[3:2] - 2'd1][s[1:0]];
  endfunction

  task automatic model_edge();
    logic [2:0][31:0] sm, cm, nx;
    if (rst) begin
      mp = '0; me = '0; mirq = '0; mrd = '0;
      return;
    end
    for (int l = 0; l < 3; l++)
      mirq[l] = |((mp[0] & me[l][0]) | (mp[1] & me[l][1]) | (mp[2] & me[l][2]));
    mrd = sel_val(reg_rsel);
    sm = '0; cm = '0;
    if (ev_vld && ev_num[6:5] != 2'd3) sm[ev_num[6:5]][ev_num[4:0]] = 1'b1;
    if (clr_vld && clr_num[6:5] != 2'd3) cm[clr_num[6:5]][clr_num[4:0]] = 1'b1;
    if (reg_wr && reg_wsel == 4'd0) cm[0] |= reg_wdata & 32'h3FFF_FFFF;
    if (reg_wr && reg_wsel == 4'd2) cm[2] |= reg_wdata;
    for (int w = 0; w < 3; w++) nx[w] = (mp[w] & ~cm[w]) | sm[w];
    if (cm[1] != 0 && nx[1] == 0) nx[0][30] = 1'b0;
    if (cm[2] != 0 && nx[2] == 0) nx[0][31] = 1'b0;
    nx[0] |= sm[0];
    if (sm[1] != 0) nx[0][30] = 1'b1;
    if (sm[2] != 0) nx[0][31] = 1'b1;
    if (reg_wr && reg_wsel[3:2] != 2'd0 && reg_wsel[1:0] != 2'd3)
      me[reg_wsel[3:2] - 2'd1][reg_wsel[1:0]] = reg_wdata;
    mp = nx;
  endtask

  task automatic idle();
    ev_vld = 0; clr_vld = 0; reg_wr = 0;
    ev_num = '0; clr_num = '0; reg_wsel = '0; reg_wdata = '0;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R3 irq lines", {29'd0, irq_c, irq_b, irq_a}, {29'd0, mirq});
    chk("R11 read data", reg_rdata, mrd);
    idle();
  endtask

  task automatic rd(input logic [3:0] s, input logic [31:0] exp, input string tag);
    reg_rsel = s;
    cyc();
    chk(tag, reg_rdata, exp);
  endtask

  task automatic ev(input logic [6:0] n);
    ev_vld = 1; ev_num = n; cyc();
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    reg_wr = 1; reg_wsel = s; reg_wdata = d; cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle();
    reg_rsel = '0;
    rst = 1;
    repeat (3) cyc();
    rst = 0;
    // R10: reset state
    chk("R10 lines low", {29'd0, irq_c, irq_b, irq_a}, 32'd0);
    rd(4'b0000, 32'h0, "R10 pending word0");
    rd(4'b0110, 32'h0, "R10 enable A word2");

    ev(7'd5);
    rd(4'b0000, 32'h0000_0020, "R1 word0 bit5");
    ev(7'h21);
    rd(4'b0001, 32'h0000_0002, "R1 word1 bit1");
    rd(4'b0000, 32'h4000_0020, "R2 cascade bit30");
    ev(7'h5F);
    rd(4'b0010, 32'h8000_0000, "R1 word2 bit31");
    rd(4'b0000, 32'hC000_0020, "R2 cascade bit31");
    ev(7'h63);
    rd(4'b0000, 32'hC000_0020, "R1 word3 event ignored w0");
    rd(4'b0001, 32'h0000_0002, "R1 word3 event ignored w1");

    wr(4'b0101, 32'h0000_0002);
    cyc();
    chk("R7 line A rises on enable", {31'd0, irq_a}, 32'd1);
    chk("R7 line B stays low", {31'd0, irq_b}, 32'd0);
    rd(4'b0101, 32'h0000_0002, "R11 enable readback");
    wr(4'b1000, 32'h0000_0020);
    cyc();
    chk("R3 line B from word0", {31'd0, irq_b}, 32'd1);
    wr(4'b1000, 32'h0);
    cyc();
    chk("R7 line B falls on enable clear", {31'd0, irq_b}, 32'd0);

    wr(4'b0001, 32'hFFFF_FFFF);
    rd(4'b0001, 32'h0000_0002, "R5 word1 write ignored");
    chk("R5 line A still high", {31'd0, irq_a}, 32'd1);

    clr_vld = 1; clr_num = 7'h21; cyc();
    rd(4'b0001, 32'h0, "R8 strobe clear word1");
    rd(4'b0000, 32'h8000_0020, "R8 cascade bit30 dropped");
    chk("R3 line A low after clear", {31'd0, irq_a}, 32'd0);

    wr(4'b0000, 32'hFFFF_FFFF);
    rd(4'b0000, 32'h8000_0000, "R4 cascade bits kept");
    wr(4'b0010, 32'h8000_0000);
    rd(4'b0010, 32'h0, "R6 word2 cleared");
    rd(4'b0000, 32'h0, "R6 cascade bit31 dropped");

    ev_vld = 1; ev_num = 7'd7; reg_wr = 1; reg_wsel = 4'b0000; reg_wdata = 32'h80; cyc();
    rd(4'b0000, 32'h0000_0080, "R9 set beats write clear");
    ev_vld = 1; ev_num = 7'h22; clr_vld = 1; clr_num = 7'h22; cyc();
    rd(4'b0001, 32'h0000_0004, "R9 set beats strobe clear");
    rd(4'b0000, 32'h4000_0080, "R9 cascade set wins");
    ev_vld = 1; ev_num = 7'h41; reg_wr = 1; reg_wsel = 4'b0010; reg_wdata = 32'hFFFF_FFFF; cyc();
    rd(4'b0010, 32'h0000_0002, "R9 word2 set beats write");
    rd(4'b0000, 32'hC000_0080, "R9 word2 cascade kept");

    wr(4'b1011, 32'hFFFF_FFFF);
    rd(4'b1011, 32'h0, "R11 word index 3 reads zero");

    for (int i = 0; i < RAND_CYC; i++) begin
      ev_vld   = $urandom_range(0, 1);
      ev_num   = 7'($urandom);
      clr_vld  = ($urandom_range(0, 3) == 0);
      clr_num  = 7'($urandom);
      reg_wr   = ($urandom_range(0, 2) == 0);
      reg_wsel = 4'($urandom);
      reg_wdata = (reg_wsel[3:2] == 2'd0) ? ($urandom & $urandom & $urandom) : $urandom;
      reg_rsel = 4'($urandom);
      if (i % 500 == 250) rst = 1;
      cyc();
      rst = 0;
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule